// File: doc/BRIEF.md
# Slice-Based Bitmap On-Screen Display Overlay

This block lays a two-bit-per-pixel bitmap over an incoming YUV pixel stream. The bitmap is not a flat frame buffer. It is a store of small vertical tiles ("slices"), each 8 pixels wide and 32 rows tall. A separate slot table lists, for each horizontal slot on the overlay line, which slice to draw there. Moving a slice to another slot, or swapping the digits of a counter display, takes one slot-table write. The bitmap itself is left unchanged.

During active video the block tracks the raster position from a frame strobe, a line strobe and a pixel strobe. It works out which slot, slice row and column each pixel falls on, and looks up the 2-bit code. A code of zero lets the input pixel through. Codes 1 to 3 replace the pixel with one of three programmable 24-bit YUV colours. Each overlay pixel covers two input pixels, so 44 slots of 8 pixels span 704 samples of the line. An optional double-height mode shows each slice row on two lines. The row word for the next slot is read one slot ahead, so slot boundaries cost no cycles.

The host writes slice rows as 16-bit words at address slice*32+row, which is the concatenation {slice[5:0], row[4:0]}. It writes slot entries as 6-bit slice numbers and palette entries as 24-bit values. Position, enable and height mode are static inputs.

Top module: `osd_slice_overlay`

## Requirements
- R1: While reset is held, and until the first pixel strobe after it, `vid_out` is 0 and `out_valid` is 0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `pix_en` high. `vid_out` changes only on pixel strobes. When `active` is low, the strobe passes `vid_in` through.
- R3: The pixel at overlay column c of a slice row word uses bits [2c+1:2c] of that word. Column 0 is the leftmost pixel and sits in the LSBs. Code 0 passes `vid_in` through unchanged.
- R4: The overlay starts at the active pixel whose index from the line strobe equals `h_start`, with index 0 being the first active pixel. It covers 704 active pixels, each overlay pixel on two consecutive active pixels. Pixels before the window, and pixels 704 or more past its start, pass through.
- R5: Overlay slot k (0 to 43) shows slice `seq[k]` at row address slice*32+row. A nonzero code outputs palette entry 1, 2 or 3 as written through `pal_idx`. Rewriting only the slot table moves slice content to new slots.
- R6: A slot whose slice number is 48 or more shows as transparent. After reset every slot holds 63.
- R7: With double height off, line index `v_start`+r for r in 0 to 31 shows slice row r. The line after `frame_start` has index 0, and each `line_start` adds one. All other lines pass through.
- R8: With double height on, line index `v_start`+r for r in 0 to 63 shows slice row r/2. The overlay is 64 lines tall.
- R9: With `osd_en` low, every pixel passes through.
- R10: Pixel strobes on every cycle of a line give correct colours across every slot boundary. This requires at least two idle cycles between a line or frame strobe and the first pixel strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osd_en | input | 1 | Overlay enable |
| dbl_en | input | 1 | Double-height mode |
| h_start | input | 10 | First active pixel index of the overlay |
| v_start | input | 10 | First line index of the overlay |
| bmp_we | input | 1 | Slice row write strobe |
| bmp_addr | input | 11 | Slice row address {slice, row} |
| bmp_wdata | input | 16 | Slice row word, 8 pixels of 2 bits |
| seq_we | input | 1 | Slot table write strobe |
| seq_slot | input | 6 | Slot number to write |
| seq_code | input | 6 | Slice number for that slot |
| pal_we | input | 1 | Palette write strobe |
| pal_idx | input | 2 | Palette entry 1 to 3 (0 is ignored) |
| pal_yuv | input | 24 | Palette colour |
| frame_start | input | 1 | Frame strobe, starts line 0 |
| line_start | input | 1 | Line strobe, starts the next line |
| pix_en | input | 1 | Pixel strobe |
| active | input | 1 | Active video qualifier |
| vid_in | input | 24 | Input YUV pixel |
| vid_out | output | 24 | Output YUV pixel |
| out_valid | output | 1 | Output pixel strobe |

## Verification
Every pixel result appears one clock after the edge that captures its strobe, from a single output register. The driver applies each strobe just after a rising edge and pushes the expected pixel into the scoreboard queue at that moment. The monitor pops and compares on the falling edge that follows the capture edge. Slice, slot-table and palette writes are made well before the line strobe of the line they affect. Every line starts with a strobe followed by two idle cycles, which gives the slot-0 prefetch time to land. Pixels are driven back to back, and also with one- and two-cycle gaps, so that slot-boundary row loads are checked at full rate.

// File: rtl/osd_pkg.sv
package osd_pkg;
   typedef logic [23:0] yuv_t;
endpackage

// File: rtl/osd_raster_pos.sv
module osd_raster_pos #(
   parameter int HPOS_W     = 10,
   parameter int VPOS_W     = 10,
   parameter int SLOT_AW    = 6,
   parameter int COL_AW     = 3,
   parameter int ROW_AW     = 5,
   parameter int HREP_LOG2  = 1,
   parameter int HSPAN      = 704,
   parameter int SLICE_ROWS = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_start,
   input  logic               line_start,
   input  logic               pix_step,
   input  logic [HPOS_W-1:0]  h_start,
   input  logic [VPOS_W-1:0]  v_start,
   input  logic               dbl_en,
   output logic               line_go,
   output logic               in_h,
   output logic               in_v,
   output logic               slot_entry,
   output logic [SLOT_AW-1:0] slot_idx,
   output logic [COL_AW-1:0]  col_idx,
   output logic [ROW_AW-1:0]  row_idx
);
   localparam int SHIFT = HREP_LOG2 + COL_AW;
   localparam logic [HPOS_W:0]   HSPAN_V = (HPOS_W+1)'(HSPAN);
   localparam logic [VPOS_W:0]   VSPAN_S = (VPOS_W+1)'(SLICE_ROWS);
   localparam logic [VPOS_W:0]   VSPAN_D = (VPOS_W+1)'(2*SLICE_ROWS);
   localparam logic [HPOS_W-1:0] SUBMASK = HPOS_W'((1 << SHIFT) - 1);

   logic [HPOS_W-1:0] h_cnt, hoff;
   logic [VPOS_W-1:0] v_cnt, voff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_cnt   <= '0;
         v_cnt   <= '0;
         line_go <= 1'b0;
      end else begin
         line_go <= frame_start | line_start;
         if (frame_start) v_cnt <= '0;
         else if (line_start) v_cnt <= v_cnt + 1'b1;
         if (frame_start || line_start) h_cnt <= '0;
         else if (pix_step && h_cnt != '1) h_cnt <= h_cnt + 1'b1;
      end
   end

   assign hoff       = h_cnt - h_start;
   assign in_h       = (h_cnt >= h_start) && ({1'b0, hoff} < HSPAN_V);
   assign slot_entry = (hoff & SUBMASK) == '0;
   assign slot_idx   = SLOT_AW'(hoff >> SHIFT);
   assign col_idx    = COL_AW'(hoff >> HREP_LOG2);

   assign voff    = v_cnt - v_start;
   assign in_v    = (v_cnt >= v_start) && ({1'b0, voff} < (dbl_en ? VSPAN_D : VSPAN_S));
   assign row_idx = ROW_AW'(dbl_en ? (voff >> 1) : voff);
endmodule

// File: rtl/osd_seq_table.sv
module osd_seq_table #(
   parameter int NUM_SLOTS  = 44,
   parameter int NUM_SLICES = 48,
   parameter int SLOT_AW    = 6,
   parameter int SLICE_AW   = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [SLOT_AW-1:0]  wr_slot,
   input  logic [SLICE_AW-1:0] wr_code,
   input  logic [SLOT_AW-1:0]  rd_slot,
   output logic [SLICE_AW-1:0] rd_code,
   output logic                rd_ok
);
   localparam logic [SLOT_AW-1:0]  SLOT_LIM  = SLOT_AW'(NUM_SLOTS);
   localparam logic [SLICE_AW-1:0] SLICE_LIM = SLICE_AW'(NUM_SLICES);

   logic [SLICE_AW-1:0] seq_q [NUM_SLOTS];
   logic slot_in_range;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SLOTS; i++) seq_q[i] <= '1;
      end else if (wr_en && wr_slot < SLOT_LIM) begin
         seq_q[wr_slot] <= wr_code;
      end
   end

   assign slot_in_range = rd_slot < SLOT_LIM;
   assign rd_code       = slot_in_range ? seq_q[rd_slot] : '1;
   assign rd_ok         = slot_in_range && (rd_code < SLICE_LIM);
endmodule

// File: rtl/osd_slice_store.sv
module osd_slice_store #(
   parameter int DEPTH  = 1536,
   parameter int AW     = 11,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              rd_ok,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_word
);
   localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en && {1'b0, wr_addr} < DEPTH_V) mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_word <= '0;
      else if (rd_en) rd_word <= (rd_ok && {1'b0, rd_addr} < DEPTH_V) ? mem[rd_addr] : '0;
   end
endmodule

// File: rtl/osd_slice_overlay.sv
module osd_slice_overlay
   import osd_pkg::*;
#(
   parameter int NUM_SLICES = 48,
   parameter int NUM_SLOTS  = 44,
   parameter int SLICE_COLS = 8,
   parameter int SLICE_ROWS = 32,
   parameter int PIX_W      = 2,
   parameter int HREP_LOG2  = 1,
   parameter int LINE_PIX   = 720,
   parameter int HPOS_W     = 10,
   parameter int VPOS_W     = 10,
   parameter bit MSB_FIRST  = 1'b0,
   localparam int WORD_W    = SLICE_COLS * PIX_W,
   localparam int SLICE_AW  = $clog2(NUM_SLICES),
   localparam int ROW_AW    = $clog2(SLICE_ROWS),
   localparam int BMP_AW    = SLICE_AW + ROW_AW,
   localparam int SLOT_AW   = $clog2(NUM_SLOTS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                osd_en,
   input  logic                dbl_en,
   input  logic [HPOS_W-1:0]   h_start,
   input  logic [VPOS_W-1:0]   v_start,
   input  logic                bmp_we,
   input  logic [BMP_AW-1:0]   bmp_addr,
   input  logic [WORD_W-1:0]   bmp_wdata,
   input  logic                seq_we,
   input  logic [SLOT_AW-1:0]  seq_slot,
   input  logic [SLICE_AW-1:0] seq_code,
   input  logic                pal_we,
   input  logic [PIX_W-1:0]    pal_idx,
   input  logic [23:0]         pal_yuv,
   input  logic                frame_start,
   input  logic                line_start,
   input  logic                pix_en,
   input  logic                active,
   input  logic [23:0]         vid_in,
   output logic [23:0]         vid_out,
   output logic                out_valid
);
   localparam int COL_AW = $clog2(SLICE_COLS);
   localparam int NCOL   = 1 << PIX_W;
   localparam int DEPTH  = NUM_SLICES * SLICE_ROWS;
   localparam int HSPAN  = (NUM_SLOTS * SLICE_COLS) << HREP_LOG2;

   generate
      if (SLICE_COLS != (1 << COL_AW)) begin : g_chk_cols
         $error("SLICE_COLS must be a power of two");
      end
      if (SLICE_ROWS != (1 << ROW_AW)) begin : g_chk_rows
         $error("SLICE_ROWS must be a power of two");
      end
      if (LINE_PIX >= (1 << HPOS_W) || HSPAN >= (1 << HPOS_W)) begin : g_chk_hpos
         $error("HPOS_W too narrow for the line");
      end
      if (VPOS_W <= ROW_AW + 1) begin : g_chk_vpos
         $error("VPOS_W too narrow for double height");
      end
      if (PIX_W < 1) begin : g_chk_pix
         $error("PIX_W must be at least one");
      end
   endgenerate

   logic                line_go, in_h, in_v, slot_entry;
   logic [SLOT_AW-1:0]  slot_idx, fetch_slot;
   logic [COL_AW-1:0]   col_idx, col_eff;
   logic [ROW_AW-1:0]   row_idx;
   logic [SLICE_AW-1:0] fetch_code;
   logic                fetch_code_ok;
   logic                pix_step, entry_step, fetch_req;
   logic [WORD_W-1:0]   nxt_word, cur_word, show_word;
   logic [PIX_W-1:0]    pix_code;
   logic                overlay;
   yuv_t                pal_q [NCOL];

   assign pix_step   = pix_en & active;
   assign entry_step = pix_step & in_h & slot_entry;
   assign fetch_req  = line_go | entry_step;
   assign fetch_slot = line_go ? '0 : slot_idx + 1'b1;

   osd_raster_pos #(
      .HPOS_W(HPOS_W), .VPOS_W(VPOS_W), .SLOT_AW(SLOT_AW), .COL_AW(COL_AW),
      .ROW_AW(ROW_AW), .HREP_LOG2(HREP_LOG2), .HSPAN(HSPAN), .SLICE_ROWS(SLICE_ROWS)
   ) u_pos (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
      .pix_step(pix_step), .h_start(h_start), .v_start(v_start), .dbl_en(dbl_en),
      .line_go(line_go), .in_h(in_h), .in_v(in_v), .slot_entry(slot_entry),
      .slot_idx(slot_idx), .col_idx(col_idx), .row_idx(row_idx)
   );

   osd_seq_table #(
      .NUM_SLOTS(NUM_SLOTS), .NUM_SLICES(NUM_SLICES), .SLOT_AW(SLOT_AW), .SLICE_AW(SLICE_AW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(seq_we), .wr_slot(seq_slot), .wr_code(seq_code),
      .rd_slot(fetch_slot), .rd_code(fetch_code), .rd_ok(fetch_code_ok)
   );

   osd_slice_store #(
      .DEPTH(DEPTH), .AW(BMP_AW), .WORD_W(WORD_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(bmp_we), .wr_addr(bmp_addr), .wr_data(bmp_wdata),
      .rd_en(fetch_req), .rd_ok(fetch_code_ok & in_v), .rd_addr({fetch_code, row_idx}),
      .rd_word(nxt_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_word <= '0;
      else if (entry_step) cur_word <= nxt_word;
   end

   assign show_word = entry_step ? nxt_word : cur_word;

   generate
      if (MSB_FIRST) begin : g_order_msb
         assign col_eff = COL_AW'(SLICE_COLS - 1) - col_idx;
      end else begin : g_order_lsb
         assign col_eff = col_idx;
      end
   endgenerate

   assign pix_code = show_word[col_eff*PIX_W +: PIX_W];

   assign pal_q[0] = '0;
   for (genvar i = 1; i < NCOL; i++) begin : g_pal
      yuv_t ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ent_q <= '0;
         else if (pal_we && pal_idx == PIX_W'(i)) ent_q <= pal_yuv;
      end
      assign pal_q[i] = ent_q;
   end

   assign overlay = osd_en & pix_step & in_h & (pix_code != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vid_out   <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= pix_en;
         if (pix_en) vid_out <= overlay ? pal_q[pix_code] : vid_in;
      end
   end

   assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pix_en |=> out_valid);
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_en |=> (!out_valid && $stable(vid_out)));
   assert_disabled_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && !osd_en) |=> (vid_out == $past(vid_in)));
   assert_clear_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && pix_code == '0) |=> (vid_out == $past(vid_in)));
   assert_outside_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && !in_h) |=> (vid_out == $past(vid_in)));
endmodule

// File: tb/osd_slice_overlay_tb_top.sv
`timescale 1ns/1ps
module osd_slice_overlay_tb_top;
   localparam int NSL = 48, NSLOT = 44, ROWS = 32, LPIX = 720;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        osd_en = 0, dbl_en = 0;
   logic [9:0]  h_start = '0, v_start = '0;
   logic        bmp_we = 0;
   logic [10:0] bmp_addr = '0;
   logic [15:0] bmp_wdata = '0;
   logic        seq_we = 0;
   logic [5:0]  seq_slot = '0, seq_code = '0;
   logic        pal_we = 0;
   logic [1:0]  pal_idx = '0;
   logic [23:0] pal_yuv = '0;
   logic        frame_start = 0, line_start = 0, pix_en = 0, active = 0;
   logic [23:0] vid_in = '0;
   logic [23:0] vid_out;
   logic        out_valid;

   osd_slice_overlay dut_i (
      .clk(clk), .rst_n(rst_n), .osd_en(osd_en), .dbl_en(dbl_en),
      .h_start(h_start), .v_start(v_start), .bmp_we(bmp_we), .bmp_addr(bmp_addr),
      .bmp_wdata(bmp_wdata), .seq_we(seq_we), .seq_slot(seq_slot), .seq_code(seq_code),
      .pal_we(pal_we), .pal_idx(pal_idx), .pal_yuv(pal_yuv), .frame_start(frame_start),
      .line_start(line_start), .pix_en(pix_en), .active(active), .vid_in(vid_in),
      .vid_out(vid_out), .out_valid(out_valid)
   );

   int checks = 0, errors = 0;
   logic [15:0] bmp_m [NSL*ROWS];
   logic [5:0]  seq_m [NSLOT];
   logic [23:0] pal_m [4];
   logic [23:0] exp_q [$];
   string       tag_q [$];
   logic [23:0] exp_v;
   string       exp_t;

   task automatic check(string req, logic [23:0] act, logic [23:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, expv);
      end
   endtask

   // monitor: pops one expected item per output strobe
   always @(negedge clk) begin
      if (rst_n && out_valid === 1'b1) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R2 actual unexpected output %h expected no output", vid_out);
         end else begin
            exp_v = exp_q.pop_front();
            exp_t = tag_q.pop_front();
            check(exp_t, vid_out, exp_v);
         end
      end
   end

   function automatic logic [23:0] model_pix(int v, int h, logic act, logic [23:0] vin,
                                             output string tag);
      int x, slot, col, row, span, code;
      logic [15:0] w;
      logic [1:0] p;
      if (!act) begin tag = "R2"; return vin; end
      if (!osd_en) begin tag = "R9"; return vin; end
      if (h < int'(h_start) || h - int'(h_start) >= 704) begin tag = "R4"; return vin; end
      x = (h - int'(h_start)) / 2; slot = x / 8; col = x % 8;
      span = dbl_en ? 64 : 32;
      if (v < int'(v_start) || v - int'(v_start) >= span) begin
         tag = dbl_en ? "R8" : "R7"; return vin;
      end
      row = dbl_en ? (v - int'(v_start)) / 2 : v - int'(v_start);
      code = int'(seq_m[slot]);
      if (code >= NSL) begin tag = "R6"; return vin; end
      w = bmp_m[code*ROWS + row];
      p = w[2*col +: 2];
      if (p == 2'd0) begin tag = "R3"; return vin; end
      if (dbl_en) tag = "R8";
      else if ((h - int'(h_start)) % 16 == 0) tag = "R10";
      else tag = "R5";
      return pal_m[p];
   endfunction

   task automatic wr_bmp(int a, logic [15:0] d);
      @(posedge clk); #1;
      bmp_we = 1; bmp_addr = 11'(a); bmp_wdata = d; bmp_m[a] = d;
      @(posedge clk); #1;
      bmp_we = 0;
   endtask

   task automatic wr_seq(int k, int code);
      @(posedge clk); #1;
      seq_we = 1; seq_slot = 6'(k); seq_code = 6'(code); seq_m[k] = 6'(code);
      @(posedge clk); #1;
      seq_we = 0;
   endtask

   task automatic wr_pal(int i, logic [23:0] c);
      @(posedge clk); #1;
      pal_we = 1; pal_idx = 2'(i); pal_yuv = c; pal_m[i] = c;
      @(posedge clk); #1;
      pal_we = 0;
   endtask

   // driver: one line of 720 active pixels, optional idle gap between pixels
   task automatic run_line(int v, bit first, int gap);
      string t;
      logic [23:0] e;
      @(posedge clk); #1;
      if (first) frame_start = 1; else line_start = 1;
      @(posedge clk); #1;
      frame_start = 0; line_start = 0;
      repeat (2) @(posedge clk);
      #1;
      for (int h = 0; h < LPIX; h++) begin
         pix_en = 1; active = 1;
         vid_in = 24'((v * 7919 + h * 131) ^ 32'h5A3C1E);
         e = model_pix(v, h, 1'b1, vid_in, t);
         exp_q.push_back(e); tag_q.push_back(t);
         @(posedge clk); #1;
         if (gap > 0) begin
            pix_en = 0; active = 0;
            repeat (gap) @(posedge clk);
            #1;
         end
      end
      pix_en = 0; active = 0;
   endtask

   task automatic run_frame(int nlines, int gap);
      for (int v = 0; v < nlines; v++) run_line(v, v == 0, gap);
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL R2 actual run still going expected finish before watchdog");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      string t;
      logic [23:0] e;
      for (int k = 0; k < NSLOT; k++) seq_m[k] = 6'h3F;
      pal_m[0] = '0; pal_m[1] = '0; pal_m[2] = '0; pal_m[3] = '0;

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", {out_valid, vid_out}, 25'd0);
      #1 rst_n = 1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R1", {out_valid, vid_out}, 25'd0);

      // R6: reset slot table is all transparent
      osd_en = 1; h_start = 10'd0; v_start = 10'd0;
      run_line(0, 1'b1, 0);

      wr_pal(1, 24'hEB8080);
      wr_pal(2, 24'h51F05A);
      wr_pal(3, 24'h29146E);
      wr_pal(0, 24'h123456);   // R3: entry 0 is never used
      pal_m[0] = '0;
      for (int a = 0; a < NSL*ROWS; a++) wr_bmp(a, 16'((a * 40503) ^ (a << 5) ^ (a >> 2)));
      for (int k = 0; k < NSLOT; k++) wr_seq(k, k);

      // R5 R7 R10: single height, back-to-back pixels
      h_start = 10'd5; v_start = 10'd2; dbl_en = 0;
      run_frame(37, 0);

      // R5 R6 R8: reordered slots without touching the bitmap, double height
      for (int k = 0; k < NSLOT; k++) wr_seq(k, 43 - k);
      wr_seq(3, 50);
      wr_seq(5, 47);
      wr_seq(9, 63);
      h_start = 10'd0; v_start = 10'd1; dbl_en = 1;
      run_frame(67, 0);

      // R9: overlay disabled, gapped pixels
      osd_en = 0; dbl_en = 0; v_start = 10'd0;
      run_frame(2, 1);

      // R4: window runs past the line end, gapped pixels
      osd_en = 1; h_start = 10'd30; v_start = 10'd0;
      run_frame(2, 2);

      // R2: strobe with active low, then idle cycle holds output
      @(posedge clk); #1;
      pix_en = 1; active = 0; vid_in = 24'hA5A5A5;
      e = model_pix(0, 0, 1'b0, vid_in, t);
      exp_q.push_back(e); tag_q.push_back(t);
      @(posedge clk); #1;
      pix_en = 0; vid_in = 24'h0F0F0F;
      @(posedge clk);
      @(negedge clk);
      check("R2", {out_valid, vid_out}, {1'b0, 24'hA5A5A5});

      repeat (4) @(posedge clk);
      @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R2 actual %0d pending outputs expected 0", exp_q.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule